// File: doc/BRIEF.md
# Emulated Non-Volatile Memory Controller

This block stands in for an embedded non-volatile array on an emulation platform. Its storage holds words that the rest of the system reads through a plain memory-mapped read port with one cycle of latency. That port never alters the array, because normal bus writes cannot change non-volatile cells. Writes sent to it are dropped.

All changes to the contents go through a separate command port. A read command returns one word. A page erase sets every word of an aligned page to all ones. A word program stores the bitwise AND of the old word and the supplied word, so a program can only clear bits.

Erase and program are made deliberately slow, each with its own cycle-count parameter, to mimic real cell timing. The block raises busy while an operation runs and pulses done when it completes. It rejects any command that arrives while it is busy, and any command with a reserved operation code, by pulsing an error flag. Reset stops an operation at once and leaves the array as it stands.

Top module: `nvm_emu_ctrl`

## Requirements
- R1: A bus read (`bus_req_i`=1, `bus_we_i`=0) presents the addressed word on `bus_rdata_o` with `bus_rvalid_o`=1 in the cycle after the request.
- R2: A bus write (`bus_req_i`=1, `bus_we_i`=1) leaves every array word unchanged and produces no `bus_rvalid_o` in the following cycle.
- R3: A read command (`cmd_op_i`=2'b01) puts the word at `cmd_addr_i` on `cmd_rdata_o` and pulses `done_o` in the cycle after acceptance, without raising `busy_o`.
- R4: An erase command (`cmd_op_i`=2'b10) sets all PAGE_WORDS words of the addressed page to all ones and leaves the words of other pages unchanged.
- R5: An erase ignores the low log2(PAGE_WORDS) bits of its address, so it always starts at the page boundary.
- R6: A program command (`cmd_op_i`=2'b11) stores the old word AND `cmd_wdata_i`. Programming the same word again without an erase is accepted without error and applies the AND rule again.
- R7: A program holds `busy_o` high for exactly PROG_CYC cycles, and the word keeps its old value while busy. `done_o` is then high for exactly one cycle, with `busy_o` low.
- R8: An erase holds `busy_o` high for exactly ERASE_CYC + PAGE_WORDS cycles, then pulses `done_o` for one cycle.
- R9: A command that arrives while `busy_o` is high is rejected. `err_o` pulses in the next cycle, the command has no effect on the array, and the running operation completes normally.
- R10: A command with the reserved code 2'b00 pulses `err_o` in the next cycle, does not raise `busy_o` and changes nothing.
- R11: A reset during an operation drops `busy_o` at once, and no further word changes. Words written before the reset keep their values.
- R12: After reset, `busy_o`, `done_o`, `err_o` and `bus_rvalid_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_req_i | input | 1 | Memory-mapped access request |
| bus_we_i | input | 1 | Access is a write (discarded) |
| bus_addr_i | input | ADDR_W | Word address of the access |
| bus_wdata_i | input | DATA_W | Write data (discarded) |
| bus_rdata_o | output | DATA_W | Read data, one cycle after the request |
| bus_rvalid_o | output | 1 | Read data valid |
| cmd_valid_i | input | 1 | Command strobe, one cycle per command |
| cmd_op_i | input | 2 | 01 read, 10 page erase, 11 program, 00 reserved |
| cmd_addr_i | input | ADDR_W | Command word address |
| cmd_wdata_i | input | DATA_W | Program data |
| cmd_rdata_o | output | DATA_W | Read-command result |
| busy_o | output | 1 | Erase or program in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | One-cycle rejection pulse |

## Verification
The assertions take for granted that the array has been erased before any program runs, because the bit-clearing check compares against the stored word and would see unknown contents otherwise. They also assume that `cmd_valid_i` is a single-cycle strobe and that `cmd_op_i` is a known value whenever the strobe is high. The stimulus erases every page first, drives each command for exactly one cycle away from the clock edge, and sends the deliberate overlapping and reserved commands only as single strobes.

// File: rtl/nvm_emu_pkg.sv
package nvm_emu_pkg;

   typedef enum logic [1:0] {
      OP_NONE  = 2'b00,
      OP_READ  = 2'b01,
      OP_ERASE = 2'b10,
      OP_PROG  = 2'b11
   } nvm_op_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'b00,
      ST_WAIT = 2'b01,
      ST_WIPE = 2'b10
   } nvm_state_e;

endpackage

// File: rtl/nvm_emu_array.sv
module nvm_emu_array #(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 8,
   parameter int NUM_RD = 3
) (
   input  logic                           clk_i,
   input  logic                           rst_ni,
   input  logic                           we_i,
   input  logic                           wipe_i,
   input  logic [ADDR_W-1:0]              wr_addr_i,
   input  logic [DATA_W-1:0]              wr_data_i,
   input  logic [NUM_RD-1:0][ADDR_W-1:0]  rd_addr_i,
   output logic [NUM_RD-1:0][DATA_W-1:0]  rd_data_o
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem_q [DEPTH];

   // Cells have no reset: contents survive a controller reset.
   always_ff @(posedge clk_i) begin
      if (we_i) begin
         mem_q[wr_addr_i] <= wr_data_i;
      end
   end

   for (genvar g = 0; g < NUM_RD; g++) begin : g_rd
      assign rd_data_o[g] = mem_q[rd_addr_i[g]];
   end

   // R6: outside an erase, a write may only clear bits of the stored word
   assert_prog_clears_only_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && !wipe_i) |-> ((wr_data_i & ~mem_q[wr_addr_i]) == '0));

endmodule

// File: rtl/nvm_emu_timer.sv
module nvm_emu_timer #(
   parameter int CNT_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   output logic             zero_o
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= load_val_i;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign zero_o = (cnt_q == '0);

   // R7 / R8: without a load the count never grows
   assert_timer_monotonic_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !load_i |=> (cnt_q <= $past(cnt_q)));

endmodule

// File: rtl/nvm_emu_busport.sv
module nvm_emu_busport #(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              req_i,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic [ADDR_W-1:0] arr_addr_o,
   input  logic [DATA_W-1:0] arr_data_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              rvalid_o
);

   assign arr_addr_o = addr_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rdata_o  <= '0;
         rvalid_o <= 1'b0;
      end else begin
         rvalid_o <= req_i && !we_i;
         if (req_i && !we_i) begin
            rdata_o <= arr_data_i;
         end
      end
   end

   // R1: every read request yields a response in the following cycle
   assert_bus_read_resp_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_i && !we_i) |=> rvalid_o);

   // R2: a write request never produces a response
   assert_bus_write_silent_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_i && we_i) |=> !rvalid_o);

endmodule

// File: rtl/nvm_emu_seq.sv
module nvm_emu_seq
   import nvm_emu_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int ADDR_W     = 8,
   parameter int PAGE_WORDS = 16,
   parameter int ERASE_CYC  = 20000,
   parameter int PROG_CYC   = 500
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              cmd_valid_i,
   input  logic [1:0]        cmd_op_i,
   input  logic [ADDR_W-1:0] cmd_addr_i,
   input  logic [DATA_W-1:0] cmd_wdata_i,
   input  logic [DATA_W-1:0] cur_word_i,
   input  logic [DATA_W-1:0] cmd_word_i,
   output logic [ADDR_W-1:0] cur_addr_o,
   output logic              we_o,
   output logic              wipe_o,
   output logic [ADDR_W-1:0] wr_addr_o,
   output logic [DATA_W-1:0] wr_data_o,
   output logic [DATA_W-1:0] cmd_rdata_o,
   output logic              busy_o,
   output logic              done_o,
   output logic              err_o
);

   localparam int PB      = $clog2(PAGE_WORDS);
   localparam int MAX_CYC = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
   localparam int CNT_W   = $clog2(MAX_CYC + 1);
   localparam logic [CNT_W-1:0] ERASE_LOAD = CNT_W'(ERASE_CYC - 1);
   localparam logic [CNT_W-1:0] PROG_LOAD  = CNT_W'(PROG_CYC - 1);
   localparam logic [PB-1:0]    LAST_IDX   = PB'(PAGE_WORDS - 1);

   nvm_state_e        state_q;
   nvm_op_e           op_q;
   nvm_op_e           cmd_op;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q;
   logic [PB-1:0]     idx_q;
   logic              tmr_load;
   logic [CNT_W-1:0]  tmr_val;
   logic              tmr_zero;
   logic              accept_slow;

   assign cmd_op      = nvm_op_e'(cmd_op_i);
   assign accept_slow = (state_q == ST_IDLE) && cmd_valid_i &&
                        ((cmd_op == OP_ERASE) || (cmd_op == OP_PROG));
   assign tmr_load    = accept_slow;
   assign tmr_val     = (cmd_op == OP_ERASE) ? ERASE_LOAD : PROG_LOAD;

   nvm_emu_timer #(
      .CNT_W (CNT_W)
   ) timer_i (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_i     (tmr_load),
      .load_val_i (tmr_val),
      .zero_o     (tmr_zero)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q     <= ST_IDLE;
         op_q        <= OP_NONE;
         addr_q      <= '0;
         data_q      <= '0;
         idx_q       <= '0;
         cmd_rdata_o <= '0;
         done_o      <= 1'b0;
         err_o       <= 1'b0;
      end else begin
         done_o <= 1'b0;
         err_o  <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (cmd_valid_i) begin
                  unique case (cmd_op)
                     OP_READ: begin
                        cmd_rdata_o <= cmd_word_i;
                        done_o      <= 1'b1;
                     end
                     OP_ERASE: begin
                        state_q <= ST_WAIT;
                        op_q    <= OP_ERASE;
                        addr_q  <= {cmd_addr_i[ADDR_W-1:PB], {PB{1'b0}}};
                     end
                     OP_PROG: begin
                        state_q <= ST_WAIT;
                        op_q    <= OP_PROG;
                        addr_q  <= cmd_addr_i;
                        data_q  <= cmd_wdata_i;
                     end
                     default: err_o <= 1'b1;
                  endcase
               end
            end
            ST_WAIT: begin
               err_o <= cmd_valid_i;
               if (tmr_zero) begin
                  if (op_q == OP_PROG) begin
                     state_q <= ST_IDLE;
                     done_o  <= 1'b1;
                  end else begin
                     state_q <= ST_WIPE;
                     idx_q   <= '0;
                  end
               end
            end
            ST_WIPE: begin
               err_o <= cmd_valid_i;
               idx_q <= idx_q + 1'b1;
               if (idx_q == LAST_IDX) begin
                  state_q <= ST_IDLE;
                  done_o  <= 1'b1;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy_o     = (state_q != ST_IDLE);
   assign cur_addr_o = addr_q;
   assign wipe_o     = (state_q == ST_WIPE);
   assign we_o       = wipe_o || ((state_q == ST_WAIT) && tmr_zero && (op_q == OP_PROG));
   assign wr_addr_o  = wipe_o ? {addr_q[ADDR_W-1:PB], idx_q} : addr_q;
   assign wr_data_o  = wipe_o ? {DATA_W{1'b1}} : (cur_word_i & data_q);

   // R9: a strobe during an operation is flagged in the next cycle
   assert_reject_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmd_valid_i && busy_o) |=> (err_o && busy_o == $past(busy_o) || err_o && done_o));

   // R10: reserved code raises error and starts nothing
   assert_reserved_code_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmd_valid_i && !busy_o && cmd_op_i == 2'b00) |=> (err_o && !busy_o));

   // R7: completion is never reported while still busy
   assert_done_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> !busy_o);

   // R8: every end of a busy period carries a done pulse
   assert_busy_end_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(busy_o) |-> done_o);

endmodule

// File: rtl/nvm_emu_ctrl.sv
module nvm_emu_ctrl #(
   parameter int DATA_W     = 32,
   parameter int ADDR_W     = 8,
   parameter int PAGE_WORDS = 16,
   parameter int ERASE_CYC  = 20000,
   parameter int PROG_CYC   = 500
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              bus_req_i,
   input  logic              bus_we_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic [DATA_W-1:0] bus_wdata_i,
   output logic [DATA_W-1:0] bus_rdata_o,
   output logic              bus_rvalid_o,
   input  logic              cmd_valid_i,
   input  logic [1:0]        cmd_op_i,
   input  logic [ADDR_W-1:0] cmd_addr_i,
   input  logic [DATA_W-1:0] cmd_wdata_i,
   output logic [DATA_W-1:0] cmd_rdata_o,
   output logic              busy_o,
   output logic              done_o,
   output logic              err_o
);

   localparam int NUM_RD  = 3;
   localparam int RD_BUS  = 0;
   localparam int RD_CUR  = 1;
   localparam int RD_CMD  = 2;

   if ((PAGE_WORDS < 2) || ((PAGE_WORDS & (PAGE_WORDS - 1)) != 0)) begin : g_bad_page
      $error("PAGE_WORDS must be a power of two of at least 2");
   end
   if ((1 << ADDR_W) < 2 * PAGE_WORDS) begin : g_bad_depth
      $error("array must hold at least two pages");
   end
   if ((ERASE_CYC < 1) || (PROG_CYC < 1) || (ERASE_CYC <= PROG_CYC)) begin : g_bad_lat
      $error("latencies must be positive and erase slower than program");
   end

   logic [NUM_RD-1:0][ADDR_W-1:0] rd_addr;
   logic [NUM_RD-1:0][DATA_W-1:0] rd_data;
   logic                          arr_we;
   logic                          arr_wipe;
   logic [ADDR_W-1:0]             arr_waddr;
   logic [DATA_W-1:0]             arr_wdata;

   nvm_emu_array #(
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W),
      .NUM_RD (NUM_RD)
   ) array_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .we_i      (arr_we),
      .wipe_i    (arr_wipe),
      .wr_addr_i (arr_waddr),
      .wr_data_i (arr_wdata),
      .rd_addr_i (rd_addr),
      .rd_data_o (rd_data)
   );

   nvm_emu_busport #(
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W)
   ) busport_i (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .req_i      (bus_req_i),
      .we_i       (bus_we_i),
      .addr_i     (bus_addr_i),
      .arr_addr_o (rd_addr[RD_BUS]),
      .arr_data_i (rd_data[RD_BUS]),
      .rdata_o    (bus_rdata_o),
      .rvalid_o   (bus_rvalid_o)
   );

   assign rd_addr[RD_CMD] = cmd_addr_i;

   nvm_emu_seq #(
      .DATA_W     (DATA_W),
      .ADDR_W     (ADDR_W),
      .PAGE_WORDS (PAGE_WORDS),
      .ERASE_CYC  (ERASE_CYC),
      .PROG_CYC   (PROG_CYC)
   ) seq_i (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .cmd_valid_i (cmd_valid_i),
      .cmd_op_i    (cmd_op_i),
      .cmd_addr_i  (cmd_addr_i),
      .cmd_wdata_i (cmd_wdata_i),
      .cur_word_i  (rd_data[RD_CUR]),
      .cmd_word_i  (rd_data[RD_CMD]),
      .cur_addr_o  (rd_addr[RD_CUR]),
      .we_o        (arr_we),
      .wipe_o      (arr_wipe),
      .wr_addr_o   (arr_waddr),
      .wr_data_o   (arr_wdata),
      .cmd_rdata_o (cmd_rdata_o),
      .busy_o      (busy_o),
      .done_o      (done_o),
      .err_o       (err_o)
   );

   // R2: the array is written only by a running command
   assert_array_write_owned_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      arr_we |-> busy_o);

   // R2: idle bus writes never reach the array
   assert_bus_write_ignored_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_req_i && bus_we_i && !busy_o) |-> !(arr_we && arr_wdata == bus_wdata_i));

endmodule

// File: tb/nvm_emu_ctrl_tb_top.sv
module nvm_emu_ctrl_tb_top;

   localparam int DW    = 32;
   localparam int AW    = 6;
   localparam int PW    = 8;
   localparam int ECYC  = 300;
   localparam int PCYC  = 40;
   localparam int DEPTH = 1 << AW;
   localparam logic [DW-1:0] ONES = {DW{1'b1}};

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_req = 1'b0;
   logic          bus_we = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic          bus_rvalid;
   logic          cmd_valid = 1'b0;
   logic [1:0]    cmd_op = 2'b00;
   logic [AW-1:0] cmd_addr = '0;
   logic [DW-1:0] cmd_wdata = '0;
   logic [DW-1:0] cmd_rdata;
   logic          busy, done, err;

   int checks = 0;
   int errors = 0;
   logic [DW-1:0] model [DEPTH];

   always #4 clk = ~clk;

   nvm_emu_ctrl #(
      .DATA_W (DW), .ADDR_W (AW), .PAGE_WORDS (PW),
      .ERASE_CYC (ECYC), .PROG_CYC (PCYC)
   ) dut_i (
      .clk_i (clk), .rst_ni (rst_n),
      .bus_req_i (bus_req), .bus_we_i (bus_we), .bus_addr_i (bus_addr),
      .bus_wdata_i (bus_wdata), .bus_rdata_o (bus_rdata), .bus_rvalid_o (bus_rvalid),
      .cmd_valid_i (cmd_valid), .cmd_op_i (cmd_op), .cmd_addr_i (cmd_addr),
      .cmd_wdata_i (cmd_wdata), .cmd_rdata_o (cmd_rdata),
      .busy_o (busy), .done_o (done), .err_o (err)
   );

   task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
      end
   endtask

   task automatic bus_read(input logic [AW-1:0] a, output logic [DW-1:0] d, output logic v);
      bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
      @(negedge clk);
      bus_req = 1'b0;
      d = bus_rdata; v = bus_rvalid;
   endtask

   task automatic issue(input logic [1:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d);
      cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_wdata = d;
      @(negedge clk);
      cmd_valid = 1'b0; cmd_op = 2'b00;
   endtask

   task automatic wait_idle(output int n);
      n = 0;
      while (busy && n < 100000) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic verify_all(input string tag);
      logic [DW-1:0] d;
      logic v;
      int bad = 0;
      for (int i = 0; i < DEPTH; i++) begin
         bus_read(AW'(i), d, v);
         if (d !== model[i] || v !== 1'b1) begin
            bad++;
            if (bad == 1) $display("FAIL %s: word %0d actual 0x%08h expected 0x%08h", tag, i, d, model[i]);
         end
      end
      checks++;
      if (bad != 0) errors++;
   endtask

   task automatic t_reset_state();
      check("R12 busy", {31'd0, busy}, 0);
      check("R12 done", {31'd0, done}, 0);
      check("R12 err", {31'd0, err}, 0);
      check("R12 rvalid", {31'd0, bus_rvalid}, 0);
   endtask

   task automatic t_erase_all();
      int n;
      for (int p = 0; p < DEPTH / PW; p++) begin
         issue(2'b10, AW'(p * PW + 3), '0);
         wait_idle(n);
         if (p == 0) begin
            check("R8 erase busy cycles", n, ECYC + PW);
            check("R8 done pulse", {31'd0, done}, 1);
            @(negedge clk);
            check("R8 done one cycle", {31'd0, done}, 0);
         end else begin
            @(negedge clk);
         end
         for (int i = 0; i < PW; i++) model[p * PW + i] = ONES;
      end
      verify_all("R4 R5 R1 full erase");
   endtask

   task automatic t_program();
      logic [DW-1:0] d;
      logic v;
      int n;
      issue(2'b11, 6'd10, 32'hF0F0_1234);
      bus_read(6'd10, d, v);
      check("R7 old value while busy", d, ONES);
      check("R1 rvalid", {31'd0, v}, 1);
      wait_idle(n);
      check("R7 program busy cycles", n + 1, PCYC);
      check("R7 done pulse", {31'd0, done}, 1);
      check("R7 busy low at done", {31'd0, busy}, 0);
      @(negedge clk);
      check("R7 done one cycle", {31'd0, done}, 0);
      model[10] = 32'hF0F0_1234;
      issue(2'b11, 6'd10, 32'h0FF0_FF00);
      check("R6 reprogram no error", {31'd0, err}, 0);
      wait_idle(n);
      @(negedge clk);
      model[10] = 32'hF0F0_1234 & 32'h0FF0_FF00;
      bus_read(6'd10, d, v);
      check("R6 AND result", d, 32'h00F0_1200);
   endtask

   task automatic t_cmd_read();
      issue(2'b01, 6'd10, '0);
      check("R3 done", {31'd0, done}, 1);
      check("R3 busy stays low", {31'd0, busy}, 0);
      check("R3 data", cmd_rdata, model[10]);
      @(negedge clk);
      issue(2'b01, 6'd11, '0);
      check("R3 data other word", cmd_rdata, ONES);
   endtask

   task automatic t_bus_write();
      bus_req = 1'b1; bus_we = 1'b1; bus_addr = 6'd10; bus_wdata = '0;
      @(negedge clk);
      bus_addr = 6'd12;
      check("R2 no rvalid", {31'd0, bus_rvalid}, 0);
      @(negedge clk);
      bus_req = 1'b0; bus_we = 1'b0;
      @(negedge clk);
      verify_all("R2 array unchanged");
   endtask

   task automatic t_page_erase();
      int n;
      issue(2'b11, 6'd17, '0); wait_idle(n); @(negedge clk); model[17] = '0;
      issue(2'b11, 6'd25, '0); wait_idle(n); @(negedge clk); model[25] = '0;
      issue(2'b11, 6'd15, 32'h1234_5678); wait_idle(n); @(negedge clk); model[15] = 32'h1234_5678;
      issue(2'b10, 6'd23, '0); wait_idle(n); @(negedge clk);
      for (int i = 16; i < 24; i++) model[i] = ONES;
      verify_all("R4 R5 single page erase");
   endtask

   task automatic t_reject();
      int n;
      issue(2'b11, 6'd30, 32'h0000_00FF);
      issue(2'b11, 6'd31, '0);
      check("R9 err pulse", {31'd0, err}, 1);
      check("R9 still busy", {31'd0, busy}, 1);
      @(negedge clk);
      check("R9 err one cycle", {31'd0, err}, 0);
      wait_idle(n);
      check("R9 first completes", {31'd0, done}, 1);
      @(negedge clk);
      model[30] = 32'h0000_00FF;
      verify_all("R9 rejected command had no effect");
   endtask

   task automatic t_reserved();
      issue(2'b00, 6'd5, '0);
      check("R10 err pulse", {31'd0, err}, 1);
      check("R10 not busy", {31'd0, busy}, 0);
      check("R10 no done", {31'd0, done}, 0);
      @(negedge clk);
      verify_all("R10 array unchanged");
   endtask

   task automatic t_reset_mid();
      issue(2'b11, 6'd40, '0);
      repeat (5) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check("R11 busy drops in reset", {31'd0, busy}, 0);
      rst_n = 1'b1;
      repeat (PCYC + 5) @(negedge clk);
      issue(2'b10, 6'd26, '0);
      repeat (20) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      check("R11 busy low after reset", {31'd0, busy}, 0);
      repeat (ECYC + PW + 5) @(negedge clk);
      verify_all("R11 aborted operations changed nothing");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset_state();
      t_erase_all();
      t_program();
      t_cmd_read();
      t_bus_write();
      t_page_erase();
      t_reject();
      t_reserved();
      t_reset_mid();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule